// File: doc/BRIEF.md
# Flash Sector Geometry and Protection Mapper

This block turns a byte address into a sector descriptor for a NOR flash array. The array is built from up to four regions placed end to end from address zero. Each region holds a power-of-two number of sectors, and every sector in a region has the same power-of-two size. For each address presented, the block reports:

- the global sector index;
- the sector's base address and size;
- whether a program or erase may touch the sector;
- whether the sector has backing storage, and where in that storage the byte sits;
- whether a read must return the erased value 0xFF.

Only sectors whose write-protect bit is clear get storage. Those sectors are packed in ascending index order into one contiguous store, so a fully protected array needs no RAM. A hardware write-protect pin adds a second, range-based lock on top of the per-sector mask. The range value is a signed parameter:

- a positive value locks that many sectors from the bottom of the array;
- a negative value locks that many sectors from the top;
- zero disables the pin.

A command decoder in front of the flash array uses the block on every access. Region geometry is fixed at elaboration. The protect mask and the pin are live inputs.

Top module: `flash_sector_mapper`

## Requirements
- R1: The descriptor is registered. `lk_valid` is high exactly in the cycle after a cycle with `req_valid` high and is low otherwise. `lk_valid` is low after reset.
- R2: `lk_sector` equals the sector counts of all earlier regions plus (offset within the region) shifted right by that region's size exponent. With the default geometry (four 8-byte sectors, then two 16-byte sectors, then one 64-byte sector) this gives indices 0 to 6.
- R3: `lk_base` is the first byte of the addressed sector, and `lk_size` is its size in bytes.
- R4: Addresses wrap modulo the total array size (128 bytes by default) before lookup. Address bits above the array size have no effect on any output.
- R5: When `lk_has_store` is 1, `lk_store_addr` equals the summed size of all unprotected sectors with a lower index plus the byte offset inside the sector.
- R6: Bit s of `prot_mask` set to 1 makes sector s unwritable and gives it no storage (`lk_has_store` = 0, `lk_writable` = 0).
- R7: With `wp_n` low and a positive range R, sectors 0 to R-1 report `lk_writable` = 0 while keeping their storage. With `wp_n` high the pin locks nothing.
- R8: With `wp_n` low and a negative range R, the last |R| sectors report `lk_writable` = 0.
- R9: With a range of zero, `wp_n` has no effect on any output.
- R10: `lk_read_ff` is 1 exactly when the sector has no storage and its end (base + size) lies beyond the initial-content length INIT_BYTES (48 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Byte address to look up |
| prot_mask | input | NSECT | Per-sector write-protect mask, bit s for sector s |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| lk_valid | output | 1 | Descriptor valid, one cycle after the request |
| lk_sector | output | IDX_W | Global sector index |
| lk_base | output | ADDR_W | Sector base byte address |
| lk_size | output | ADDR_W+1 | Sector size in bytes |
| lk_writable | output | 1 | Program or erase allowed |
| lk_has_store | output | 1 | Sector has backing storage |
| lk_store_addr | output | ADDR_W | Address in the packed store (meaningful when `lk_has_store` is 1) |
| lk_read_ff | output | 1 | Reads of this byte return 0xFF |

## Verification
The hardest case to reach from the ports is a packed storage address that depends on a mix of protected and unprotected lower sectors. It only shows up when the mask has holes below the addressed sector. The bench therefore sweeps every byte address, each with different upper address bits, under several masks with interior holes: none, all, alternate and sparse. It does this for both pin levels. Three instances with positive, negative and zero range values share the same stimulus, so the two pin directions and the disabled pin are compared on identical addresses.

// File: rtl/flash_sector_mapper.sv
module flash_sector_mapper #(
  parameter int ADDR_W      = 16,
  parameter int NUM_REGIONS = 3,
  parameter int R0_CNT      = 4,
  parameter int R0_SZL      = 3,
  parameter int R1_CNT      = 2,
  parameter int R1_SZL      = 4,
  parameter int R2_CNT      = 1,
  parameter int R2_SZL      = 6,
  parameter int R3_CNT      = 1,
  parameter int R3_SZL      = 3,
  parameter int WP_RANGE    = 2,
  parameter int INIT_BYTES  = 48,
  localparam int NSECT      = (NUM_REGIONS > 0 ? R0_CNT : 0) + (NUM_REGIONS > 1 ? R1_CNT : 0)
                            + (NUM_REGIONS > 2 ? R2_CNT : 0) + (NUM_REGIONS > 3 ? R3_CNT : 0),
  localparam int IDX_W      = NSECT > 1 ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              wp_n,
  output logic              lk_valid,
  output logic [IDX_W-1:0]  lk_sector,
  output logic [ADDR_W-1:0] lk_base,
  output logic [ADDR_W:0]   lk_size,
  output logic              lk_writable,
  output logic              lk_has_store,
  output logic [ADDR_W-1:0] lk_store_addr,
  output logic              lk_read_ff
);

  function automatic int rcnt(int i);
    if (i >= NUM_REGIONS) return 0;
    case (i)
      0: return R0_CNT;
      1: return R1_CNT;
      2: return R2_CNT;
      default: return R3_CNT;
    endcase
  endfunction

  function automatic int rszl(int i);
    case (i)
      0: return R0_SZL;
      1: return R1_SZL;
      2: return R2_SZL;
      default: return R3_SZL;
    endcase
  endfunction

  function automatic int rbytes(int i);
    return rcnt(i) << rszl(i);
  endfunction

  function automatic int rstart(int i);
    int a = 0;
    for (int k = 0; k < 4; k++) if (k < i) a += rbytes(k);
    return a;
  endfunction

  function automatic int rsidx(int i);
    int a = 0;
    for (int k = 0; k < 4; k++) if (k < i) a += rcnt(k);
    return a;
  endfunction

  function automatic int sect_szl(int s);
    int z = 0;
    for (int k = 0; k < 4; k++)
      if (s >= rsidx(k) && s < rsidx(k) + rcnt(k)) z = rszl(k);
    return z;
  endfunction

  localparam int TOTAL  = rstart(4);
  localparam int PIN_LO = WP_RANGE < 0 ? NSECT + WP_RANGE : 0;
  localparam int PIN_HI = WP_RANGE > 0 ? WP_RANGE : (WP_RANGE < 0 ? NSECT : 0);

  logic [31:0]      wa;
  logic [3:0]       hit;
  logic [IDX_W-1:0] idx_c;
  logic [31:0]      base_c, off_c, pbase_c, store_total;
  int               szl_c;
  logic             has_c, pin_lock, wr_c, ff_c;

  assign wa = 32'(req_addr) & 32'(TOTAL - 1);

  for (genvar g = 0; g < 4; g++) begin : g_hit
    assign hit[g] = (rcnt(g) > 0) && (wa >= 32'(rstart(g))) && (wa < 32'(rstart(g) + rbytes(g)));
  end

  always_comb begin
    idx_c  = '0;
    base_c = '0;
    szl_c  = 0;
    off_c  = '0;
    for (int g = 0; g < 4; g++) begin
      if (hit[g]) begin
        off_c  = wa - 32'(rstart(g));
        idx_c  = IDX_W'(32'(rsidx(g)) + (off_c >> rszl(g)));
        base_c = 32'(rstart(g)) + ((off_c >> rszl(g)) << rszl(g));
        szl_c  = rszl(g);
      end
    end
  end

  always_comb begin
    store_total = '0;
    pbase_c     = '0;
    for (int s = 0; s < NSECT; s++) begin
      if (IDX_W'(s) == idx_c) pbase_c = store_total;
      if (!prot_mask[s]) store_total = store_total + (32'd1 << sect_szl(s));
    end
  end

  assign has_c    = !prot_mask[idx_c];
  assign pin_lock = !wp_n && (32'(idx_c) >= 32'(PIN_LO)) && (32'(idx_c) < 32'(PIN_HI));
  assign wr_c     = has_c && !pin_lock;
  assign ff_c     = !has_c && ((base_c + (32'd1 << szl_c)) > 32'(INIT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid      <= 1'b0;
      lk_sector     <= '0;
      lk_base       <= '0;
      lk_size       <= '0;
      lk_writable   <= 1'b0;
      lk_has_store  <= 1'b0;
      lk_store_addr <= '0;
      lk_read_ff    <= 1'b0;
    end else begin
      lk_valid <= req_valid;
      if (req_valid) begin
        lk_sector     <= idx_c;
        lk_base       <= base_c[ADDR_W-1:0];
        lk_size       <= (ADDR_W+1)'(1) << szl_c;
        lk_writable   <= wr_c;
        lk_has_store  <= has_c;
        lk_store_addr <= ADDR_W'(pbase_c + (wa - base_c));
        lk_read_ff    <= ff_c;
      end
    end
  end

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(hit) == 1); // R2
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lk_valid); // R1
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ((ADDR_W+1)'(lk_base) & (lk_size - 1'b1)) == '0); // R3
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_has_store) |-> !lk_writable); // R6
  AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && has_c) |=> (32'(lk_store_addr) < $past(store_total))); // R5
  AST_FF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_read_ff) |-> !lk_has_store); // R10

endmodule

// File: tb/flash_sector_mapper_tb.sv
`timescale 1ns/1ps
module flash_sector_mapper_tb_top;
  localparam int NS = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [NS-1:0] prot_mask = '0;
  logic wp_n = 1'b1;

  always #2.5 clk = ~clk;

  logic        v_p, v_n, v_z;
  logic [2:0]  s_p, s_n, s_z;
  logic [15:0] b_p, b_n, b_z, a_p, a_n, a_z;
  logic [16:0] z_p, z_n, z_z;
  logic        w_p, w_n2, w_z, h_p, h_n, h_z, f_p, f_n, f_z;

  flash_sector_mapper #(.WP_RANGE(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .prot_mask(prot_mask), .wp_n(wp_n), .lk_valid(v_p), .lk_sector(s_p),
    .lk_base(b_p), .lk_size(z_p), .lk_writable(w_p), .lk_has_store(h_p),
    .lk_store_addr(a_p), .lk_read_ff(f_p));
  flash_sector_mapper #(.WP_RANGE(-2)) dut_neg_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .prot_mask(prot_mask), .wp_n(wp_n), .lk_valid(v_n), .lk_sector(s_n),
    .lk_base(b_n), .lk_size(z_n), .lk_writable(w_n2), .lk_has_store(h_n),
    .lk_store_addr(a_n), .lk_read_ff(f_n));
  flash_sector_mapper #(.WP_RANGE(0)) dut_zero_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .prot_mask(prot_mask), .wp_n(wp_n), .lk_valid(v_z), .lk_sector(s_z),
    .lk_base(b_z), .lk_size(z_z), .lk_writable(w_z), .lk_has_store(h_z),
    .lk_store_addr(a_z), .lk_read_ff(f_z));

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s addr=%0h mask=%b wp_n=%b actual=%0d expected=%0d",
               req, req_addr, prot_mask, wp_n, got, exp);
    end
  endtask

  function automatic int ssz(int s);
    return s < 4 ? 8 : (s < 6 ? 16 : 64);
  endfunction
  function automatic int sbase(int s);
    return s < 4 ? s * 8 : (s < 6 ? 32 + (s - 4) * 16 : 64);
  endfunction

  task automatic check_one(int rng, int s_g, int b_g, int z_g, int w_g, int h_g, int a_g, int f_g);
    int w, idx, has, wr, pb, lock;
    w = int'(req_addr) % 128;
    idx = 0;
    for (int s = 0; s < NS; s++) if (w >= sbase(s) && w < sbase(s) + ssz(s)) idx = s;
    has = prot_mask[idx] ? 0 : 1;
    pb = 0;
    for (int s = 0; s < NS; s++) if (s < idx && !prot_mask[s]) pb += ssz(s);
    lock = 0;
    if (!wp_n && rng > 0 && idx < rng) lock = 1;
    if (!wp_n && rng < 0 && idx >= NS + rng) lock = 1;
    wr = (has && !lock) ? 1 : 0;
    chk("R2 R4 sector", s_g, idx);
    chk("R3 R4 base", b_g, sbase(idx));
    chk("R3 size", z_g, ssz(idx));
    chk("R6 has_store", h_g, has);
    if (has == 1) chk("R5 store_addr", a_g, pb + w - sbase(idx));
    if (rng > 0) chk("R7 writable", w_g, wr);
    else if (rng < 0) chk("R8 writable", w_g, wr);
    else chk("R9 writable", w_g, wr);
    chk("R10 read_ff", f_g, (!has && sbase(idx) + ssz(idx) > 48) ? 1 : 0);
  endtask

  initial begin
    logic [NS-1:0] masks [4];
    masks[0] = 7'b0000000; masks[1] = 7'b1111111;
    masks[2] = 7'b1010101; masks[3] = 7'b0100110;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", v_p, 0);
    chk("R1 reset valid", v_n, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle valid", v_p, 0);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 256; a++) begin
          @(negedge clk);
          req_valid = 1'b1;
          req_addr  = 16'((a << 9) ^ a);
          prot_mask = masks[m];
          wp_n      = p[0];
          @(posedge clk); #1;
          chk("R1 valid", v_p, 1);
          check_one(2, s_p, b_p, z_p, w_p, h_p, a_p, f_p);
          check_one(-2, s_n, b_n, z_n, w_n2, h_n, a_n, f_n);
          check_one(0, s_z, b_z, z_z, w_z, h_z, a_z, f_z);
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 valid drop", v_p, 0);
    chk("R1 valid drop", v_z, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule